// File: doc/BRIEF.md
# Tagged Conversion Result Queue

This block sits between a conversion sequencer and a register-read port. Each conversion result arrives with a small tag that names the control slot that produced it, and tag and result are queued together in a 16-entry synchronous FIFO. A read strobe removes one entry. The value appears on the read outputs one cycle later and stays there until the next successful read.

Software watches the queue through one status word. That word shows both internal pointers, the empty and full flags, an occupancy-versus-watermark flag and a sticky overrun flag. The watermark level can be set from 1 to 16 entries and is stored as the level minus one.

There are three interrupt sources: overrun, watermark and end of sequence. Each has its own enable bit, and the raw and masked bits use the same positions as the enables. A global enable gates the single combined interrupt line.

Top module: `tagres_fifo`

## Requirements
- R1: After a synchronous reset, the status word reads empty=1, full=0, overrun=0 and watermark=0, with both pointers at 0. The read outputs are 0, all raw and masked interrupt bits are 0, and `irq` is 0.
- R2: Entries leave the queue in the order they were written, with tag and result kept together. After a read strobe on a non-empty queue, `rd_tag`/`rd_data` show the popped entry from the next cycle on.
- R3: The queue holds 16 entries, and status bit 3 (full) is set when it holds 16. A write while full is discarded: the write pointer stays where it is and the stored contents do not change. The same write sets the overrun flag, which is status bit 1.
- R4: The overrun flag is sticky. Reads do not clear it, and neither do further writes. Only reset or a flush clears it.
- R5: A read strobe while the queue is empty (status bit 2) does not move the read pointer. The read outputs keep the last value read.
- R6: `wm_sel` holds the watermark level minus one, so codes 0..15 mean levels 1..16. Status bit 0 is 1 exactly when the occupancy is at or above that level. It drops in the cycle after a read takes the occupancy below the level.
- R7: Status bits 7:4 show the read pointer and bits 11:8 show the write pointer. Both wrap from 15 to 0.
- R8: Raw interrupt bit 0 is overrun, bit 1 is the watermark condition and bit 2 is end of sequence. `int_en` uses the same bit positions. `masked_int` is `raw_int` ANDed with `int_en`.
- R9: `irq` is high exactly when `int_global` is 1 and at least one `masked_int` bit is 1.
- R10: Raw bit 2 is set by `eos_set` and cleared by `eos_clr`. If both arrive in the same cycle, the set wins. A flush does not touch this bit.
- R11: A flush empties the queue, returns both pointers to 0 and clears overrun. It takes priority over a write or read in the same cycle, and it leaves the read outputs unchanged.
- R12: A write and a read in the same cycle on a queue that is neither empty nor full both take effect. Each pointer advances by one and the occupancy does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empty the queue and clear overrun |
| wr_en | input | 1 | Write strobe from the sequencer |
| wr_tag | input | 4 | Tag of the incoming result |
| wr_data | input | 10 | Incoming conversion result |
| rd_en | input | 1 | Read strobe, pops one entry |
| rd_tag | output | 4 | Tag of the last popped entry |
| rd_data | output | 10 | Result of the last popped entry |
| wm_sel | input | 4 | Watermark level minus one |
| int_en | input | 3 | Per-source enables: 0 overrun, 1 watermark, 2 end of sequence |
| int_global | input | 1 | Global interrupt enable |
| eos_set | input | 1 | End-of-sequence event |
| eos_clr | input | 1 | Clear the end-of-sequence raw bit |
| fifo_status | output | 12 | {wptr, rptr, full, empty, overrun, at_watermark} |
| raw_int | output | 3 | Raw interrupt status |
| masked_int | output | 3 | Raw status ANDed with enables |
| irq | output | 1 | Combined interrupt request |

## Verification
Some properties are checked on every cycle:
- the occupancy never passes the depth;
- a dropped write leaves the write pointer alone;
- a read on an empty queue changes neither the read pointer nor the read outputs;
- overrun stays set until a flush;
- a flush leaves the queue empty with overrun clear.

Other behaviour shows only in the bench scenarios, which compare against a queue model:
- ordering across a pointer wrap;
- which entry survives a dropped write;
- the watermark edges at codes 0, 3 and 15;
- the interrupt enable and global gating combinations;
- the set-over-clear rule for end of sequence.

// File: rtl/tagres_fifo_pkg.sv
package tagres_fifo_pkg;
    localparam int TAG_W = 4;
    localparam int RES_W = 10;
    localparam int IRQ_N = 3;
    localparam int IRQ_OVR = 0;
    localparam int IRQ_WM  = 1;
    localparam int IRQ_EOS = 2;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [RES_W-1:0] res;
    } res_entry_t;

    function automatic logic wm_reached(input int unsigned occ, input int unsigned level_m1);
        return occ >= level_m1 + 1;
    endfunction
endpackage

// File: rtl/tagres_fifo_core.sv
module tagres_fifo_core
    import tagres_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             wr_en,
    input  res_entry_t       wr_word,
    input  logic             rd_en,
    output res_entry_t       rd_word,
    output logic [PTR_W-1:0] rptr,
    output logic [PTR_W-1:0] wptr,
    output logic [CNT_W-1:0] occ,
    output logic             empty,
    output logic             full,
    output logic             drop
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    res_entry_t mem [DEPTH];
    logic push, pop;

    assign empty = (occ == '0);
    assign full  = (occ == FULL_CNT);
    assign push  = wr_en & ~full & ~flush;
    assign pop   = rd_en & ~empty & ~flush;
    assign drop  = wr_en & full & ~flush;

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= wr_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rptr    <= '0;
            wptr    <= '0;
            occ     <= '0;
            rd_word <= '0;
        end else if (flush) begin
            rptr <= '0;
            wptr <= '0;
            occ  <= '0;
        end else begin
            if (push) wptr <= (wptr == PTR_LAST) ? '0 : wptr + 1'b1;
            if (pop) begin
                rd_word <= mem[rptr];
                rptr    <= (rptr == PTR_LAST) ? '0 : rptr + 1'b1;
            end
            case ({push, pop})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end

    // R3
    occ_bound_chk: assert property (@(posedge clk) disable iff (rst) occ <= FULL_CNT);
    // R3
    drop_hold_chk: assert property (@(posedge clk) disable iff (rst) drop |=> $stable(wptr));
    // R5
    empty_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && empty && !flush) |=> ($stable(rptr) && $stable(rd_word)));
endmodule

// File: rtl/tagres_fifo_irq.sv
module tagres_fifo_irq
    import tagres_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             drop,
    input  logic [CNT_W-1:0] occ,
    input  logic [PTR_W-1:0] wm_sel,
    input  logic [IRQ_N-1:0] int_en,
    input  logic             int_global,
    input  logic             eos_set,
    input  logic             eos_clr,
    output logic             ovr,
    output logic             at_wm,
    output logic [IRQ_N-1:0] raw,
    output logic [IRQ_N-1:0] masked,
    output logic             irq
);
    logic eos;

    assign at_wm = wm_reached(32'(occ), 32'(wm_sel));

    always_ff @(posedge clk) begin
        if (rst || flush) ovr <= 1'b0;
        else if (drop)    ovr <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)          eos <= 1'b0;
        else if (eos_set) eos <= 1'b1;
        else if (eos_clr) eos <= 1'b0;
    end

    always_comb begin
        raw          = '0;
        raw[IRQ_OVR] = ovr;
        raw[IRQ_WM]  = at_wm;
        raw[IRQ_EOS] = eos;
    end

    assign masked = raw & int_en;
    assign irq    = int_global & (|masked);

    // R4
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst) (ovr && !flush) |=> ovr);
    // R11
    flush_clr_chk: assert property (@(posedge clk) disable iff (rst) flush |=> (!ovr && occ == '0));
    // R10
    eos_set_chk: assert property (@(posedge clk) disable iff (rst) eos_set |=> raw[IRQ_EOS]);
endmodule

// File: rtl/tagres_fifo.sv
module tagres_fifo
    import tagres_fifo_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        flush,
    input  logic        wr_en,
    input  logic [3:0]  wr_tag,
    input  logic [9:0]  wr_data,
    input  logic        rd_en,
    output logic [3:0]  rd_tag,
    output logic [9:0]  rd_data,
    input  logic [3:0]  wm_sel,
    input  logic [2:0]  int_en,
    input  logic        int_global,
    input  logic        eos_set,
    input  logic        eos_clr,
    output logic [11:0] fifo_status,
    output logic [2:0]  raw_int,
    output logic [2:0]  masked_int,
    output logic        irq
);
    localparam int DEPTH = 16;
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    res_entry_t       wr_word, rd_word;
    logic [PTR_W-1:0] rptr, wptr;
    logic [CNT_W-1:0] occ;
    logic             empty, full, drop, ovr, at_wm;

    assign wr_word.tag = wr_tag;
    assign wr_word.res = wr_data;
    assign rd_tag      = rd_word.tag;
    assign rd_data     = rd_word.res;

    tagres_fifo_core #(.DEPTH(DEPTH)) u_core (
        .clk(clk), .rst(rst), .flush(flush),
        .wr_en(wr_en), .wr_word(wr_word), .rd_en(rd_en), .rd_word(rd_word),
        .rptr(rptr), .wptr(wptr), .occ(occ),
        .empty(empty), .full(full), .drop(drop)
    );

    tagres_fifo_irq #(.DEPTH(DEPTH)) u_irq (
        .clk(clk), .rst(rst), .flush(flush), .drop(drop), .occ(occ),
        .wm_sel(wm_sel), .int_en(int_en), .int_global(int_global),
        .eos_set(eos_set), .eos_clr(eos_clr),
        .ovr(ovr), .at_wm(at_wm), .raw(raw_int), .masked(masked_int), .irq(irq)
    );

    assign fifo_status = {wptr, rptr, full, empty, ovr, at_wm};

    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst) irq |-> (int_global && masked_int != 3'b000));
endmodule

// File: tb/sim_tagres_fifo.sv
`timescale 1ns/1ps
module sim_tagres_fifo;
    logic clk = 1'b0;
    logic rst, flush, wr_en, rd_en, int_global, eos_set, eos_clr;
    logic [3:0] wr_tag, rd_tag, wm_sel;
    logic [9:0] wr_data, rd_data;
    logic [2:0] int_en, raw_int, masked_int;
    logic [11:0] fifo_status;
    logic irq;

    int n_chk = 0;
    int n_bad = 0;

    logic [13:0] q[$];
    int m_r = 0, m_w = 0;
    bit m_ovr = 0, m_eos = 0;
    logic [13:0] m_last = '0;

    always #2 clk = ~clk;

    tagres_fifo u0 (
        .clk(clk), .rst(rst), .flush(flush), .wr_en(wr_en), .wr_tag(wr_tag),
        .wr_data(wr_data), .rd_en(rd_en), .rd_tag(rd_tag), .rd_data(rd_data),
        .wm_sel(wm_sel), .int_en(int_en), .int_global(int_global),
        .eos_set(eos_set), .eos_clr(eos_clr), .fifo_status(fifo_status),
        .raw_int(raw_int), .masked_int(masked_int), .irq(irq)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [11:0] exp_status();
        bit wm = q.size() >= int'(wm_sel) + 1;
        return {m_w[3:0], m_r[3:0], q.size() == 16, q.size() == 0, m_ovr, wm};
    endfunction

    task automatic cyc(input bit w, input logic [3:0] t, input logic [9:0] d, input bit r, input bit fl);
        bit was_full, was_empty;
        wr_en = w; wr_tag = t; wr_data = d; rd_en = r; flush = fl;
        @(posedge clk);
        was_full = (q.size() == 16);
        was_empty = (q.size() == 0);
        if (fl) begin
            q.delete(); m_r = 0; m_w = 0; m_ovr = 0;
        end else begin
            if (r && !was_empty) begin
                m_last = q.pop_front();
                m_r = (m_r + 1) % 16;
            end
            if (w) begin
                if (was_full) m_ovr = 1;
                else begin q.push_back({t, d}); m_w = (m_w + 1) % 16; end
            end
        end
        @(negedge clk);
        wr_en = 0; rd_en = 0; flush = 0;
    endtask

    task automatic t_reset();
        chk("R1", "status", fifo_status, 12'h004);
        chk("R1", "rd out", {rd_tag, rd_data}, 0);
        chk("R1", "raw", raw_int, 0);
        chk("R1", "masked", masked_int, 0);
        chk("R1", "irq", irq, 0);
    endtask

    task automatic t_order();
        cyc(1, 4'h3, 10'h155, 0, 0);
        cyc(1, 4'hA, 10'h2AA, 0, 0);
        cyc(1, 4'h7, 10'h0F0, 0, 0);
        chk("R7", "ptrs after 3 writes", fifo_status, exp_status());
        for (int i = 0; i < 3; i++) begin
            cyc(0, 0, 0, 1, 0);
            chk("R2", "popped entry", {rd_tag, rd_data}, m_last);
        end
        chk("R2", "status after drain", fifo_status, exp_status());
    endtask

    task automatic t_empty_read();
        logic [13:0] prev = {rd_tag, rd_data};
        logic [11:0] st = fifo_status;
        cyc(0, 0, 0, 1, 0);
        chk("R5", "rd out held", {rd_tag, rd_data}, prev);
        chk("R5", "status unchanged", fifo_status, st);
    endtask

    task automatic t_full();
        logic [13:0] prev;
        cyc(0, 0, 0, 0, 1);
        chk("R11", "flush status", fifo_status, 12'h004);
        for (int i = 0; i < 16; i++) cyc(1, 4'(i), 10'(i * 37 + 5), 0, 0);
        chk("R3", "full status", fifo_status, exp_status());
        chk("R7", "wptr wrapped", fifo_status[11:8], 0);
        cyc(1, 4'hF, 10'h3FF, 0, 0);
        chk("R3", "overrun set, wptr held", fifo_status, exp_status());
        chk("R3", "ovr bit", fifo_status[1], 1);
        cyc(0, 0, 0, 1, 0);
        chk("R3", "head survives drop", {rd_tag, rd_data}, {4'h0, 10'd5});
        for (int i = 0; i < 15; i++) begin
            cyc(0, 0, 0, 1, 0);
            if (i == 14) chk("R2", "last entry", {rd_tag, rd_data}, m_last);
        end
        chk("R4", "overrun sticky after drain", fifo_status, exp_status());
        cyc(1, 4'h1, 10'h001, 0, 0);
        chk("R4", "overrun sticky after write", fifo_status[1], 1);
        prev = {rd_tag, rd_data};
        cyc(1, 4'h2, 10'h002, 1, 1);
        chk("R11", "flush wins", fifo_status, 12'h004);
        chk("R11", "rd out kept", {rd_tag, rd_data}, prev);
    endtask

    task automatic t_wm();
        wm_sel = 4'd3;
        for (int i = 0; i < 3; i++) cyc(1, 4'h5, 10'(i), 0, 0);
        chk("R6", "below level 4", fifo_status[0], 0);
        cyc(1, 4'h5, 10'd3, 0, 0);
        chk("R6", "at level 4", fifo_status[0], 1);
        cyc(0, 0, 0, 1, 0);
        chk("R6", "drops below level", fifo_status[0], 0);
        cyc(0, 0, 0, 0, 1);
        wm_sel = 4'd0;
        @(negedge clk);
        chk("R6", "level1 empty", fifo_status[0], 0);
        cyc(1, 4'h1, 10'd9, 0, 0);
        chk("R6", "level1 one entry", fifo_status[0], 1);
        wm_sel = 4'd15;
        for (int i = 0; i < 14; i++) cyc(1, 4'h2, 10'(i), 0, 0);
        chk("R6", "level16 at 15", fifo_status[0], 0);
        cyc(1, 4'h2, 10'd99, 0, 0);
        chk("R6", "level16 at 16", fifo_status, exp_status());
        cyc(0, 0, 0, 0, 1);
    endtask

    task automatic t_simul();
        cyc(1, 4'h4, 10'h044, 0, 0);
        cyc(1, 4'h6, 10'h066, 0, 0);
        cyc(1, 4'h8, 10'h088, 1, 0);
        chk("R12", "both pointers moved", fifo_status, exp_status());
        chk("R12", "pop result", {rd_tag, rd_data}, {4'h4, 10'h044});
        chk("R12", "occupancy two", q.size(), 2);
        cyc(0, 0, 0, 0, 1);
    endtask

    task automatic t_irq();
        wm_sel = 4'd0;
        int_en = 3'b000; int_global = 1;
        eos_set = 1; @(negedge clk); eos_set = 0;
        chk("R10", "eos raw set", raw_int, 3'b100);
        chk("R8", "masked none enabled", masked_int, 0);
        chk("R9", "irq off with no enables", irq, 0);
        int_en = 3'b100; @(negedge clk);
        chk("R9", "irq eos", irq, 1);
        int_global = 0; @(negedge clk);
        chk("R9", "global off", irq, 0);
        int_global = 1;
        eos_set = 1; eos_clr = 1; @(negedge clk); eos_set = 0; eos_clr = 0;
        chk("R10", "set wins", raw_int[2], 1);
        eos_clr = 1; @(negedge clk); eos_clr = 0;
        chk("R10", "eos cleared", raw_int[2], 0);
        eos_set = 1; @(negedge clk); eos_set = 0;
        cyc(1, 4'h1, 10'h001, 0, 0);
        chk("R8", "raw wm+eos", raw_int, 3'b110);
        int_en = 3'b010; @(negedge clk);
        chk("R8", "masked wm", masked_int, 3'b010);
        for (int i = 0; i < 16; i++) cyc(1, 4'h1, 10'h002, 0, 0);
        int_en = 3'b001; @(negedge clk);
        chk("R8", "raw all", raw_int, 3'b111);
        chk("R8", "masked ovr", masked_int, 3'b001);
        chk("R9", "irq ovr", irq, 1);
        cyc(0, 0, 0, 0, 1);
        chk("R10", "flush keeps eos", raw_int, 3'b100);
        chk("R9", "irq after flush", irq, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1; flush = 0; wr_en = 0; rd_en = 0; wr_tag = 0; wr_data = 0;
        wm_sel = 4'd3; int_en = 0; int_global = 0; eos_set = 0; eos_clr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        t_reset();
        t_order();
        t_empty_read();
        t_full();
        t_empty_read();
        t_wm();
        t_simul();
        t_irq();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule